// File: doc/BRIEF.md
# Two-Channel Current DAC Setting Slave on a Two-Wire Bus

This block is a two-wire serial bus slave that holds the settings of a pair of bidirectional current DACs. A host addresses it with a fixed 7-bit device address and selects one of two 8-bit setting registers, at memory addresses F8h and F9h, with a memory-address byte. The host then either writes a new setting or reads the current one back after a repeated START. The bus pins are sampled by a fast system clock through synchronizers. The data line is returned as a plain "pull low" enable, so no tri-state logic is needed inside.

Each setting register is read as sign and magnitude. The top bit picks the current direction and the low seven bits give the step count. The block turns this into a 7-bit magnitude, a sink enable and a source enable for each channel. Both enables stay off whenever the magnitude is zero. On reset both registers are clear, so the analog stage starts at zero current.

There is no data stream at the block's edge. The bus pins and the per-channel controls are plain signals, with no valid/ready handshake and no back-pressure.

Top module: `cdac_bus_slave`

## Requirements
- R1: After reset both setting registers hold 00h, every channel shows magnitude 0 with sink and source enables low, and the data-line pull-low enable is low.
- R2: The device address is 1001000b. An address byte of 90h (write) or 91h (read) is acknowledged. Any other address byte is not acknowledged, and all following bytes are ignored (no acknowledge, no register change) until the next START.
- R3: A write is START, 90h, a memory-address byte, then a data byte, all MSB first. The slave acknowledges each byte by pulling the data line low during the ninth clock. Memory address F8h selects channel 0 and F9h selects channel 1.
- R4: Register bit 7 is the sign: 0 enables sink and 1 enables source. Bits 6:0 appear unchanged on the channel's magnitude output. A register changes only when a data byte is written to it.
- R5: When bits 6:0 are zero, both the sink and source enables are low, whatever bit 7 holds.
- R6: A data byte written to any memory address other than F8h or F9h is acknowledged and discarded, leaving both channels unchanged. A read from such an address returns 00h.
- R7: Further data bytes in the same write go to the same register, with no address increment. The last byte wins, and the other channel is not touched.
- R8: A read is a memory-address write, a repeated START, then 91h. The slave returns the addressed register MSB first and changes the data line only after SCL falls. A master acknowledge repeats the same register. A master NACK ends the read.
- R9: A START or repeated START at any point, including in the middle of a byte phase, restarts address matching without writing anything. A STOP returns the slave to idle.
- R10: The pull-low enable is released outside the slave's acknowledge and read-bit slots. In particular it is released after a master NACK and after every STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |
| ch_mag_o | output | 14 | Magnitudes, channel 0 in bits 6:0, channel 1 in bits 13:7 |
| ch_sink_o | output | 2 | Sink enable per channel (bit n = channel n) |
| ch_source_o | output | 2 | Source enable per channel (bit n = channel n) |

## Verification
The setting path is driven with a source value (AAh), a sink value (35h), and the zero-magnitude patterns 80h and 00h. These separate a correct sign split from a swapped one and show that a zero magnitude overrides the sign. A foreign address, an unmapped memory address and a three-byte burst show whether address matching, range decoding and the no-increment rule are really applied, because each of them is followed by a check that the untouched channel kept its value. Repeated STARTs inside a write, and a two-byte read ending in NACK, show that the address phase restarts cleanly and that read data and the pull-low release follow the SCL edges.

// File: rtl/cdac_pkg.sv
package cdac_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_PTR,
    PH_DATA,
    PH_READ
  } phase_e;
endpackage

// File: rtl/cdac_pin_sync.sv
module cdac_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_q     = scl_pipe[STAGES-1];
  assign sda_q     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_q & ~scl_prev;
  assign scl_fall  = ~scl_q & scl_prev;
  // data edges while the clock is high on both samples mark frame boundaries
  assign start_det = scl_q & scl_prev & sda_prev & ~sda_q;
  assign stop_det  = scl_q & scl_prev & ~sda_prev & sda_q;
endmodule

// File: rtl/cdac_bus_engine.sv
module cdac_bus_engine
  import cdac_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1001000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_q,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_byte,
  output logic [7:0] ptr_o,
  output logic       wr_stb_o,
  output logic [7:0] wr_byte_o,
  output logic       pull_o
);
  phase_e     ph;
  logic [3:0] cnt;
  logic [7:0] sh, tx;
  logic       rnw, mnack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      cnt       <= '0;
      sh        <= '0;
      tx        <= '0;
      rnw       <= 1'b0;
      mnack     <= 1'b1;
      ptr_o     <= '0;
      wr_stb_o  <= 1'b0;
      wr_byte_o <= '0;
      pull_o    <= 1'b0;
    end else begin
      wr_stb_o <= 1'b0;
      if (start_det) begin
        ph     <= PH_DEV;
        cnt    <= '0;
        pull_o <= 1'b0;
      end else if (stop_det) begin
        ph     <= PH_IDLE;
        cnt    <= '0;
        pull_o <= 1'b0;
      end else if (ph != PH_IDLE) begin
        if (scl_rise) begin
          if (cnt < 4'd9) cnt <= cnt + 4'd1;
          if (ph == PH_READ) begin
            if (cnt == 4'd8) mnack <= sda_q;
          end else if (cnt < 4'd8) begin
            sh <= {sh[6:0], sda_q};
          end
        end else if (scl_fall) begin
          if (cnt == 4'd8) begin
            case (ph)
              PH_DEV: begin
                if (sh[7:1] == DEV_ADDR) begin
                  pull_o <= 1'b1;
                  rnw    <= sh[0];
                end else begin
                  ph <= PH_IDLE;
                end
              end
              PH_PTR: begin
                ptr_o  <= sh;
                pull_o <= 1'b1;
              end
              PH_DATA: begin
                wr_stb_o  <= 1'b1;
                wr_byte_o <= sh;
                pull_o    <= 1'b1;
              end
              default: pull_o <= 1'b0;
            endcase
          end else if (cnt == 4'd9) begin
            cnt <= '0;
            case (ph)
              PH_DEV: begin
                if (rnw) begin
                  ph     <= PH_READ;
                  tx     <= rd_byte;
                  pull_o <= ~rd_byte[7];
                end else begin
                  ph     <= PH_PTR;
                  pull_o <= 1'b0;
                end
              end
              PH_PTR: begin
                ph     <= PH_DATA;
                pull_o <= 1'b0;
              end
              PH_DATA: pull_o <= 1'b0;
              default: begin
                if (mnack) begin
                  ph     <= PH_IDLE;
                  pull_o <= 1'b0;
                end else begin
                  tx     <= rd_byte;
                  pull_o <= ~rd_byte[7];
                end
              end
            endcase
          end else if (ph == PH_READ && cnt != 4'd0) begin
            pull_o <= ~tx[3'(4'd7 - cnt)];
          end
        end
      end
    end
  end

  // R10: idle slave never pulls the line
  assert_idle_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_IDLE) |-> !pull_o);

  // R8: line changes only after an SCL fall or a frame boundary
  assert_edge_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_o != $past(pull_o)) |-> $past(scl_fall || start_det || stop_det));

  // R3: an acknowledge begins only once eight bits have been taken
  assert_ack_after_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pull_o) && ph != PH_READ) |-> (cnt == 4'd8));

  // R2: register writes only come from the data phase of a matched write
  assert_write_in_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> ($past(ph) == PH_DATA));
endmodule

// File: rtl/cdac_chan.sv
module cdac_chan #(
  parameter int MAG_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [MAG_W:0]   wr_val,
  output logic [MAG_W:0]   set_q,
  output logic [MAG_W-1:0] mag_o,
  output logic             sink_o,
  output logic             source_o
);
  logic nonzero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) set_q <= '0;
    else if (wr_en) set_q <= wr_val;
  end

  assign mag_o    = set_q[MAG_W-1:0];
  assign nonzero  = |set_q[MAG_W-1:0];
  assign sink_o   = nonzero & ~set_q[MAG_W];
  assign source_o = nonzero & set_q[MAG_W];

  // R4: a setting only moves on its own write strobe
  assert_hold_setting_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(set_q));
endmodule

// File: rtl/cdac_bus_slave.sv
module cdac_bus_slave #(
  parameter logic [6:0] DEV_ADDR  = 7'b1001000,
  parameter logic [7:0] BASE_ADDR = 8'hF8,
  parameter int         NCH       = 2,
  parameter int         MAG_W     = 7,
  parameter int         SYNC_N    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_pull_o,
  output logic [NCH*MAG_W-1:0] ch_mag_o,
  output logic [NCH-1:0]       ch_sink_o,
  output logic [NCH-1:0]       ch_source_o
);
  localparam int REG_W = MAG_W + 1;

  logic scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] ptr, wr_byte, rd_byte;
  logic       wr_stb;
  logic [REG_W-1:0] set_q [NCH];
  logic [NCH-1:0]   hit;

  cdac_pin_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  cdac_bus_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_q(sda_q), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_byte(rd_byte), .ptr_o(ptr), .wr_stb_o(wr_stb), .wr_byte_o(wr_byte),
    .pull_o(sda_pull_o)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [7:0] MY_ADDR = BASE_ADDR + 8'(i);
    assign hit[i] = (ptr == MY_ADDR);
    cdac_chan #(.MAG_W(MAG_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_stb & hit[i]),
      .wr_val(wr_byte[REG_W-1:0]), .set_q(set_q[i]),
      .mag_o(ch_mag_o[i*MAG_W +: MAG_W]), .sink_o(ch_sink_o[i]),
      .source_o(ch_source_o[i])
    );
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < NCH; i++)
      if (hit[i]) rd_byte = 8'(set_q[i]);
  end

  // R5: a direction enable implies a non-zero magnitude on every channel
  for (genvar i = 0; i < NCH; i++) begin : g_chk
    assert_zero_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_sink_o[i] || ch_source_o[i]) |-> (ch_mag_o[i*MAG_W +: MAG_W] != '0));
  end
endmodule

// File: tb/cdac_bus_slave_tb_top.sv
module cdac_bus_slave_tb_top;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_bus;
  logic sda_pull;
  logic [13:0] mag;
  logic [1:0] sink, src;
  logic [7:0] exp_set [2];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign sda_bus = sda_m & ~sda_pull;

  cdac_bus_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .ch_mag_o(mag), .ch_sink_o(sink), .ch_source_o(src)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int k = 7; k >= 0; k--) begin
      sda_m = b[k]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl = 1'b1; wq();
    ack = ~sda_bus;
    wq(); scl = 1'b0; wq();
  endtask

  task automatic get_byte(input logic master_ack, output logic [7:0] b);
    for (int k = 7; k >= 0; k--) begin
      sda_m = 1'b1; wq(); scl = 1'b1; wq();
      b[k] = sda_bus;
      wq(); scl = 1'b0; wq();
    end
    sda_m = ~master_ack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  task automatic chk_ch(input string tag);
    for (int i = 0; i < 2; i++) begin
      logic [6:0] m;
      m = exp_set[i][6:0];
      chk({tag, " mag"}, int'(mag[i*7 +: 7]), int'(m));
      chk({tag, " sink"}, int'(sink[i]), int'(m != 0 && !exp_set[i][7]));
      chk({tag, " source"}, int'(src[i]), int'(m != 0 && exp_set[i][7]));
    end
  endtask

  task automatic wr_reg(input string tag, input logic [7:0] ra, input logic [7:0] d);
    logic a;
    bus_start();
    put_byte(8'h90, a); chk({tag, " dev ack"}, int'(a), 1);
    put_byte(ra, a);    chk({tag, " ptr ack"}, int'(a), 1);
    put_byte(d, a);     chk({tag, " data ack"}, int'(a), 1);
    bus_stop();
  endtask

  task automatic t_reset();
    chk_ch("R1 reset");
    chk("R1 pull idle", int'(sda_pull), 0);
  endtask

  task automatic t_write_source();
    wr_reg("R3 write F8", 8'hF8, 8'hAA);
    exp_set[0] = 8'hAA;
    chk_ch("R4 source F8=AA");
  endtask

  task automatic t_write_sink();
    wr_reg("R3 write F9", 8'hF9, 8'h35);
    exp_set[1] = 8'h35;
    chk_ch("R4 sink F9=35");
  endtask

  task automatic t_zero();
    wr_reg("R5 write", 8'hF8, 8'h80);
    exp_set[0] = 8'h80;
    chk_ch("R5 zero source sign");
    wr_reg("R5 write", 8'hF9, 8'h00);
    exp_set[1] = 8'h00;
    chk_ch("R5 zero sink sign");
  endtask

  task automatic t_foreign();
    logic a;
    bus_start();
    put_byte(8'hA0, a); chk("R2 foreign nack", int'(a), 0);
    put_byte(8'hF8, a); chk("R2 ignored ptr", int'(a), 0);
    put_byte(8'h7F, a); chk("R2 ignored data", int'(a), 0);
    bus_stop();
    chk_ch("R2 foreign no change");
    bus_start();
    put_byte(8'h91, a); chk("R2 read addr ack", int'(a), 1);
    begin
      logic [7:0] b;
      get_byte(1'b0, b);
    end
    bus_stop();
  endtask

  task automatic t_unmapped();
    logic a;
    logic [7:0] b;
    wr_reg("R6 write F7", 8'hF7, 8'h5A);
    chk_ch("R6 unmapped no change");
    bus_start();
    put_byte(8'h90, a); put_byte(8'hF7, a);
    bus_start();
    put_byte(8'h91, a);
    get_byte(1'b0, b);
    bus_stop();
    chk("R6 unmapped read", int'(b), 0);
  endtask

  task automatic t_burst();
    logic a;
    bus_start();
    put_byte(8'h90, a); put_byte(8'hF9, a);
    put_byte(8'h11, a); chk("R7 byte1 ack", int'(a), 1);
    put_byte(8'h22, a); chk("R7 byte2 ack", int'(a), 1);
    put_byte(8'h93, a); chk("R7 byte3 ack", int'(a), 1);
    bus_stop();
    exp_set[1] = 8'h93;
    chk_ch("R7 last byte same reg");
  endtask

  task automatic t_read();
    logic a;
    logic [7:0] b;
    wr_reg("R8 prep", 8'hF8, 8'hC4);
    exp_set[0] = 8'hC4;
    bus_start();
    put_byte(8'h90, a); put_byte(8'hF8, a);
    bus_start();
    put_byte(8'h91, a); chk("R8 read addr ack", int'(a), 1);
    get_byte(1'b1, b);  chk("R8 first byte", int'(b), 8'hC4);
    get_byte(1'b0, b);  chk("R8 repeat byte", int'(b), 8'hC4);
    wq();
    chk("R10 released after nack", int'(sda_pull), 0);
    bus_stop();
    chk("R10 released after stop", int'(sda_pull), 0);
    bus_start();
    put_byte(8'h90, a); put_byte(8'hF9, a);
    bus_start();
    put_byte(8'h91, a);
    get_byte(1'b0, b);  chk("R8 read F9", int'(b), 8'h93);
    bus_stop();
  endtask

  task automatic t_restart();
    logic a;
    bus_start();
    put_byte(8'h90, a); put_byte(8'hF8, a);
    bus_start();
    put_byte(8'h90, a); chk("R9 restart dev ack", int'(a), 1);
    put_byte(8'hF8, a); put_byte(8'h55, a);
    bus_stop();
    exp_set[0] = 8'h55;
    chk_ch("R9 restart after ptr");
    bus_start();
    put_byte(8'h90, a); put_byte(8'hF9, a);
    for (int k = 7; k >= 4; k--) begin
      sda_m = 1'b0; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    end
    bus_start();
    put_byte(8'h90, a); chk("R9 mid-byte restart ack", int'(a), 1);
    put_byte(8'hF9, a); put_byte(8'h01, a);
    bus_stop();
    exp_set[1] = 8'h01;
    chk_ch("R9 restart mid byte");
    chk("R10 idle after stop", int'(sda_pull), 0);
  endtask

  initial begin
    exp_set[0] = 8'h00;
    exp_set[1] = 8'h00;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    wq();
    t_reset();
    t_write_source();
    t_write_sink();
    t_zero();
    t_foreign();
    t_unmapped();
    t_burst();
    t_read();
    t_restart();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule